// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a bus-side producer into an asynchronous serial bit stream. A single holding register sits in front of a shift register. While one character is being shifted out, the next one can already be written into the holding register. Bit timing comes entirely from a one-cycle `baud_tick` pulse, which the surrounding logic issues once per bit period. The line changes only on the clock edge that samples a tick.

Characters carry 8 data bits, or 9 in the wide mode. In the wide mode the ninth bit is taken from a side input at the moment of the write. Optional parity can take the place of the most significant data bit. Each time the enable rises, the transmitter first sends one all-high frame as a preamble. A break request sends frames that are low in every position. Two status flags, holding-register empty and transmission complete, are each gated by their own enable to form an interrupt request.

Top module: `serial_tx_unit`

## Requirements
- R1: On each rising edge of `tx_en`, the first frame sent is an all-high preamble whose length equals the current frame length. No character starts before the preamble has been fully sent.
- R2: When no character is buffered and no break is requested, `txd` stays high.
- R3: A character frame starts with a low start bit. The data bits follow, least significant first, and the frame ends with one high stop bit. The frame is 10 bits long when `nine_bit_mode`=0 and 11 bits when it is 1. In the 11-bit frame, the ninth data bit is the value `wr_bit9` had during the write.
- R4: With `par_en`=1, the last data position (bit 7, or bit 8 in nine-bit mode) carries a parity bit computed over the data bits below it. With `par_odd`=0 the parity is even: the count of ones including the parity bit is even. With `par_odd`=1 the parity is odd.
- R5: When the shifter is free, the buffered character is moved into it on a baud tick. On that move `buf_empty` goes to 1 and the start bit appears. A character written during a frame follows the stop bit with no idle gap. `txd` never changes on a cycle without a tick.
- R6: While `send_break` is 1 and the shifter is free, frames that are low in every position, stop included, are sent. Each break frame has the current frame length. Break takes priority over buffered data, but not over a pending preamble.
- R7: `tx_done` is 1 after reset. It goes to 1 when a frame ends and nothing new starts while the holding register is empty. It goes to 0 on a write (`wr_stb`) or when any frame starts.
- R8: When `tx_en` drops, the frame in progress completes and the line then stays high. While `tx_en` is 0, no new frame starts and a written character stays buffered (`buf_empty`=0).
- R9: `irq_empty` equals `buf_empty` AND `ie_empty`. `irq_done` equals `tx_done` AND `ie_done`.
- R10: After reset, `txd`=1, `buf_empty`=1 and `tx_done`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmitter enable |
| nine_bit_mode | input | 1 | 1 selects 9 data bits (11-bit frame) |
| par_en | input | 1 | Parity replaces the top data bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| send_break | input | 1 | Request break frames |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character written on `wr_stb` |
| wr_bit9 | input | 1 | Ninth data bit latched with `wr_data` |
| ie_empty | input | 1 | Interrupt enable for holding-register empty |
| ie_done | input | 1 | Interrupt enable for transmission complete |
| txd | output | 1 | Serial output line, idle high |
| buf_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Transmission complete |
| irq_empty | output | 1 | Holding-register-empty interrupt request |
| irq_done | output | 1 | Transmission-complete interrupt request |

## Verification
The hardest situation to create is a character written during the short window after one frame's move into the shifter, so that it must follow the stop bit with no gap. The bench locks onto the tick phase, writes a character two cycles after a tick, checks `buf_empty` before the next tick and again after it, and then writes the second character at once. A line log records one sample per tick and is used to check both frames back to back. A second hard case is dropping `tx_en` in the middle of a frame and writing while disabled. The bench then re-enables the transmitter and checks that the buffered character appears exactly one preamble length later.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [1:0] {
    FK_IDLE = 2'd0,
    FK_PRE  = 2'd1,
    FK_BRK  = 2'd2,
    FK_DATA = 2'd3
  } fkind_e;
endpackage

// File: rtl/stx_holdbuf.sv
module stx_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              take,
  output logic [DATA_W-1:0] data_q,
  output logic              bit9_q,
  output logic              empty_q
);
  logic empty_n;

  // a write wins over a transfer in the same cycle: the transfer used the old value
  always_comb begin
    empty_n = empty_q;
    if (wr_stb)    empty_n = 1'b0;
    else if (take) empty_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      data_q  <= '0;
      bit9_q  <= 1'b0;
    end else begin
      empty_q <= empty_n;
      if (wr_stb) begin
        data_q <= wr_data;
        bit9_q <= wr_bit9;
      end
    end
  end

  p_write_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !empty_q);
endmodule

// File: rtl/stx_framer.sv
module stx_framer
  import stx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 3,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  fkind_e             kind,
  input  logic [DATA_W-1:0]  data,
  input  logic               bit9,
  input  logic               nine_bit_mode,
  input  logic               par_en,
  input  logic               par_odd,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   len
);
  localparam int DW1 = DATA_W + 1;

  logic [DW1-1:0]     dv;
  logic [FRAME_W-1:0] data_frame;
  logic               acc;
  int                 nbits;

  always_comb begin
    nbits = nine_bit_mode ? DW1 : DATA_W;
    dv    = {bit9, data};
    acc   = 1'b0;
    for (int i = 0; i < DW1; i++) begin
      if (i < nbits - 1) acc = acc ^ dv[i];
    end
    for (int i = 0; i < DW1; i++) begin
      if (par_en && (i == nbits - 1)) dv[i] = acc ^ par_odd;
    end
    data_frame    = '1;
    data_frame[0] = 1'b0;
    for (int i = 0; i < DW1; i++) begin
      if (i < nbits) data_frame[i+1] = dv[i];
    end
    case (kind)
      FK_PRE:  frame = '1;
      FK_BRK:  frame = '0;
      default: frame = data_frame;
    endcase
    len = CNT_W'(nbits + 2);
  end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
  parameter int FRAME_W = 11,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   len,
  output logic               busy,
  output logic               last,
  output logic               txd
);
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CNT_W'(1));
  assign txd  = busy ? sh_q[0] : 1'b1;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (tick) begin
      if (load) begin
        sh_n  = frame;
        cnt_n = len;
      end else if (busy) begin
        sh_n  = {1'b1, sh_q[FRAME_W-1:1]};
        cnt_n = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end

  p_stable_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd));
endmodule

// File: rtl/serial_tx_unit.sv
module serial_tx_unit
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              nine_bit_mode,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              send_break,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              ie_empty,
  input  logic              ie_done,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_done,
  output logic              irq_empty,
  output logic              irq_done
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               en_q, pre_q, tc_q;
  logic               en_n, pre_n, tc_n;
  fkind_e             kind_q, kind_n, sel_kind;
  logic               pre_eff, slot;
  logic               load_pre, load_brk, load_dat, load_any;
  logic               busy, last;
  logic [DATA_W-1:0]  buf_data;
  logic               buf_bit9;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   flen;

  stx_holdbuf #(.DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .wr_bit9 (wr_bit9),
    .take    (load_dat),
    .data_q  (buf_data),
    .bit9_q  (buf_bit9),
    .empty_q (buf_empty)
  );

  stx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .kind          (sel_kind),
    .data          (buf_data),
    .bit9          (buf_bit9),
    .nine_bit_mode (nine_bit_mode),
    .par_en        (par_en),
    .par_odd       (par_odd),
    .frame         (frame),
    .len           (flen)
  );

  stx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (baud_tick),
    .load  (load_any),
    .frame (frame),
    .len   (flen),
    .busy  (busy),
    .last  (last),
    .txd   (txd)
  );

  // a preamble is owed from the cycle the enable rises
  assign pre_eff  = pre_q | (tx_en & ~en_q);
  assign slot     = baud_tick & tx_en & (~busy | last);
  assign load_pre = slot & pre_eff;
  assign load_brk = slot & ~pre_eff & send_break;
  assign load_dat = slot & ~pre_eff & ~send_break & ~buf_empty;
  assign load_any = load_pre | load_brk | load_dat;

  always_comb begin
    if (load_pre)      sel_kind = FK_PRE;
    else if (load_brk) sel_kind = FK_BRK;
    else if (load_dat) sel_kind = FK_DATA;
    else               sel_kind = FK_DATA;
  end

  always_comb begin
    en_n = tx_en;
    if (!tx_en || load_pre) pre_n = 1'b0;
    else                    pre_n = pre_eff;
    if (load_any)                  kind_n = sel_kind;
    else if (baud_tick && last)    kind_n = FK_IDLE;
    else                           kind_n = kind_q;
    if (wr_stb || load_any)                    tc_n = 1'b0;
    else if (baud_tick && last && buf_empty)   tc_n = 1'b1;
    else                                       tc_n = tc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pre_q  <= 1'b0;
      kind_q <= FK_IDLE;
      tc_q   <= 1'b1;
    end else begin
      en_q   <= en_n;
      pre_q  <= pre_n;
      kind_q <= kind_n;
      tc_q   <= tc_n;
    end
  end

  assign tx_done   = tc_q;
  assign irq_empty = buf_empty & ie_empty;
  assign irq_done  = tc_q & ie_done;

  p_pre_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q == FK_PRE) |-> txd);
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_dat |=> !txd);
  p_empty_on_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_dat && !wr_stb) |=> buf_empty);
  p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q == FK_BRK) |-> !txd);
  p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !tx_done);
  p_done_only_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !busy);
  p_no_start_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> !busy);
endmodule

// File: tb/test_serial_tx_unit.sv
module test_serial_tx_unit;
  localparam int TP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       tx_en = 1'b0, nine = 1'b0, pe = 1'b0, po = 1'b0, brk = 1'b0;
  logic       wr_stb = 1'b0, wr_b9 = 1'b0, ie_e = 1'b0, ie_d = 1'b0;
  logic [7:0] wr_data = '0;
  logic       txd, buf_empty, tx_done, irq_empty, irq_done;

  int checks = 0, errors = 0;

  serial_tx_unit i_serial_tx_unit (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .nine_bit_mode(nine), .par_en(pe), .par_odd(po), .send_break(brk),
    .wr_stb(wr_stb), .wr_data(wr_data), .wr_bit9(wr_b9),
    .ie_empty(ie_e), .ie_done(ie_d), .txd(txd), .buf_empty(buf_empty),
    .tx_done(tx_done), .irq_empty(irq_empty), .irq_done(irq_done));

  always #5 clk = ~clk;

  int tcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      tcnt = 0;
      baud_tick = 1'b0;
    end else begin
      tcnt = (tcnt + 1) % TP;
      baud_tick = (tcnt == 0);
    end
  end

  // one line sample per bit period, taken one cycle after each tick
  bit   txlog [16384];
  int   nlog = 0;
  logic tick_q = 1'b0;
  always @(posedge clk) begin
    if (tick_q && nlog < 16384) begin
      txlog[nlog] = txd;
      nlog++;
    end
    tick_q = baud_tick;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_log(input int n);
    while (nlog < n) @(negedge clk);
  endtask

  task automatic write_char(input logic [7:0] d, input logic b);
    wr_data = d; wr_b9 = b; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  function automatic int flen(input logic n9);
    return n9 ? 11 : 10;
  endfunction

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic b,
                                            input logic n9, input logic p_en, input logic p_od);
    int nb = n9 ? 9 : 8;
    logic [8:0] v = {b, d};
    int ones = 0;
    logic [10:0] r = '1;
    for (int i = 0; i < nb - 1; i++) ones += int'(v[i]);
    if (p_en) v[nb-1] = ones[0] ^ p_od;
    r[0] = 1'b0;
    for (int i = 0; i < nb; i++) r[i+1] = v[i];
    return r;
  endfunction

  function automatic logic [10:0] grab(input int s, input int l);
    logic [10:0] r = '1;
    for (int i = 0; i < l; i++) r[i] = txlog[s+i];
    return r;
  endfunction

  function automatic int find_zero(input int from, input int span);
    for (int i = from; i < from + span; i++) if (txlog[i] == 1'b0) return i;
    return -1;
  endfunction

  // R3 / R4: one character through an enabled, idle transmitter
  task automatic send_check(input logic [7:0] d, input logic b, input logic n9,
                            input logic p_en, input logic p_od);
    int l = flen(n9);
    int base, s;
    logic [10:0] e;
    nine = n9; pe = p_en; po = p_od;
    base = nlog;
    write_char(d, b);
    wait_log(base + l + 4);
    s = find_zero(base, 3);
    e = exp_frame(d, b, n9, p_en, p_od);
    if (s < 0) chk(1'b0, p_en ? "R4 no start" : "R3 no start", 0, 1);
    else begin
      chk(grab(s, l) == e, p_en ? "R4 frame" : "R3 frame", int'(grab(s, l)), int'(e));
      chk(txlog[s+l] == 1'b1, "R3 idle after stop", int'(txlog[s+l]), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base, s, l, z;
    logic [7:0] dv [7] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(txd == 1'b1, "R10 txd", int'(txd), 1);
    chk(buf_empty == 1'b1, "R10 buf_empty", int'(buf_empty), 1);
    chk(tx_done == 1'b1, "R10 tx_done", int'(tx_done), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 interrupt gating with both flags set
    for (int k = 0; k < 4; k++) begin
      ie_e = k[0]; ie_d = k[1];
      @(negedge clk);
      chk(irq_empty == k[0], "R9 irq_empty", int'(irq_empty), int'(k[0]));
      chk(irq_done == k[1], "R9 irq_done", int'(irq_done), int'(k[1]));
    end

    // R2 / R8: disabled, nothing sent; R1 preamble with no data then idle
    base = nlog;
    tx_en = 1'b1;
    wait_log(base + 30);
    chk(find_zero(base, 30) < 0, "R2 idle high after preamble", find_zero(base, 30), -1);

    // R3 / R4 sweep over modes, parity and data
    for (int m = 0; m < 8; m++) begin
      for (int di = 0; di < 7; di++) begin
        for (int b = 0; b < 2; b++) begin
          send_check(dv[di], b[0], m[0], m[1], m[2]);
        end
      end
    end
    chk(tx_done == 1'b1, "R7 done after last frame", int'(tx_done), 1);

    // R5 / R7: write between ticks, flag timing, back-to-back frames
    nine = 1'b0; pe = 1'b0; po = 1'b0; l = 10;
    @(negedge clk);
    while (baud_tick !== 1'b1) @(negedge clk);
    @(negedge clk);
    base = nlog;
    write_char(8'hC3, 1'b0);
    chk(buf_empty == 1'b0, "R5 full before tick", int'(buf_empty), 0);
    chk(tx_done == 1'b0, "R7 cleared by write", int'(tx_done), 0);
    while (baud_tick !== 1'b1) @(negedge clk);
    @(negedge clk);
    chk(buf_empty == 1'b1, "R5 empty after move", int'(buf_empty), 1);
    chk(txd == 1'b0, "R5 start bit on move", int'(txd), 0);
    write_char(8'h96, 1'b0);
    wait_log(base + 2 * l + 4);
    s = find_zero(base, 3);
    chk(grab(s, l) == exp_frame(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0), "R5 first frame",
        int'(grab(s, l)), int'(exp_frame(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0)));
    chk(grab(s + l, l) == exp_frame(8'h96, 1'b0, 1'b0, 1'b0, 1'b0), "R5 back-to-back frame",
        int'(grab(s + l, l)), int'(exp_frame(8'h96, 1'b0, 1'b0, 1'b0, 1'b0)));
    chk(tx_done == 1'b1, "R7 set at end", int'(tx_done), 1);

    // R6 break: exactly one all-low frame in 9-bit mode
    nine = 1'b1; l = 11;
    base = nlog;
    brk = 1'b1;
    wait_log(base + 1);
    brk = 1'b0;
    wait_log(base + 2 * l + 2);
    s = find_zero(base, 3);
    z = 0;
    if (s >= 0) while (txlog[s+z] == 1'b0 && z < 40) z++;
    chk(z == l, "R6 break length", z, l);
    chk(tx_done == 1'b1, "R7 done after break", int'(tx_done), 1);

    // R8: drop enable mid-frame, frame completes, later write held
    nine = 1'b0; l = 10;
    base = nlog;
    write_char(8'h4E, 1'b0);
    wait_log(base + 3);
    tx_en = 1'b0;
    wait_log(base + l + 6);
    s = find_zero(base, 3);
    chk(grab(s, l) == exp_frame(8'h4E, 1'b0, 1'b0, 1'b0, 1'b0), "R8 frame completes",
        int'(grab(s, l)), int'(exp_frame(8'h4E, 1'b0, 1'b0, 1'b0, 1'b0)));
    base = nlog;
    write_char(8'h3B, 1'b0);
    wait_log(base + 25);
    chk(find_zero(base, 25) < 0, "R8 no start while disabled", find_zero(base, 25), -1);
    chk(buf_empty == 1'b0, "R8 char kept", int'(buf_empty), 0);
    chk(tx_done == 1'b0, "R7 write clears done", int'(tx_done), 0);

    // R1: re-enable with char buffered -> preamble then char, both modes
    base = nlog;
    tx_en = 1'b1;
    wait_log(base + 2 * l + 4);
    chk(find_zero(base, l + 3) == base + l, "R1 preamble 10", find_zero(base, l + 3) - base, l);
    chk(grab(base + l, l) == exp_frame(8'h3B, 1'b0, 1'b0, 1'b0, 1'b0), "R1 char after preamble",
        int'(grab(base + l, l)), int'(exp_frame(8'h3B, 1'b0, 1'b0, 1'b0, 1'b0)));
    tx_en = 1'b0;
    wait_log(nlog + 14);
    nine = 1'b1; l = 11;
    base = nlog;
    tx_en = 1'b1;
    write_char(8'hE7, 1'b1);
    wait_log(base + 2 * l + 4);
    chk(find_zero(base, l + 3) == base + l, "R1 preamble 11", find_zero(base, l + 3) - base, l);
    chk(grab(base + l, l) == exp_frame(8'hE7, 1'b1, 1'b1, 1'b0, 1'b0), "R3 nine-bit after preamble",
        int'(grab(base + l, l)), int'(exp_frame(8'hE7, 1'b1, 1'b1, 1'b0, 1'b0)));

    ie_e = 1'b1; ie_d = 1'b1;
    @(negedge clk);
    chk(irq_done == 1'b1 && irq_empty == 1'b1, "R9 both requests", int'({irq_done, irq_empty}), 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule